// File: doc/BRIEF.md
# Fused Multiply-Add Mantissa Datapath

This block is the arithmetic core of a single-precision fused multiply-add unit. It takes three unpacked operands x, y and z. Each has a sign, a signed exponent and a 24-bit mantissa whose top bit (the hidden one) is already set, so denormals must be normalised upstream. The block forms the exact product x·y and aligns it against z. It then adds or subtracts the two and normalises the result. The output is a sign, an exponent and a 27-bit mantissa: 24 significant bits followed by guard, round and sticky bits. A separate stage then rounds and packs this result.

Three more inputs steer the block. A negate-product control turns the operation into z − x·y. A z-is-zero indicator makes the block pass the bare product through. The rounding-mode input only selects the sign of an exactly cancelled result. Special values are handled elsewhere, and so is the final rounding. All intermediate shifts to the right keep lost bits as a sticky bit, so the downstream rounder is the only place where precision is lost. The result is registered one cycle after an accepted operation.

Top module: `fma_mant_core`

## Requirements
- R1: After a synchronous active-low reset, out_valid is 0 and all outputs are 0. out_valid is high exactly in the cycle after in_valid was high. The result appears on that cycle and holds unchanged while in_valid stays low.
- R2: The product exponent is x_exp + y_exp. When the mantissa product is 2.0 or more, the exponent is one larger and the product is renormalised.
- R3: The product sign is x_sign XOR y_sign XOR neg_prod.
- R4: When z_zero is 1, the output is the product alone (sign from R3, exponent from R2). z_sign, z_exp and z_mant have no effect on the output.
- R5: The operand with the smaller exponent is shifted right by the exponent difference, and the result takes the larger exponent. Every bit shifted out is ORed into bit 0 of the 64-bit working word. A shift of 63 or more leaves only that sticky bit.
- R6: When the product sign equals z_sign, the aligned words are added. A carry past the leading position causes a one-bit sticky right shift and increments the exponent.
- R7: When the signs differ, the smaller magnitude is subtracted from the larger, and the result takes the sign of the larger.
- R8: An exact zero difference gives out_mant = 0 and out_exp = 0. out_sign is then 1 only when rmode = 2'b11 (toward minus infinity). The other rmode encodings are 2'b00 nearest, 2'b01 toward zero and 2'b10 toward plus infinity.
- R9: A non-zero result always has out_mant[26] = 1. After cancellation, the exponent drops by one for every position the word is shifted left.
- R10: out_mant[26:1] are working-word bits 62..37. out_mant[0] is bit 36 ORed with all bits below it.
- R11: Exponents are 10-bit two's complement. Intermediate values outside the single-precision range (for example 255 or −298) appear unwrapped on out_exp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| x_sign | input | 1 | Sign of x |
| x_exp | input | 10 | Signed exponent of x |
| x_mant | input | 24 | Mantissa of x, hidden bit set |
| y_sign | input | 1 | Sign of y |
| y_exp | input | 10 | Signed exponent of y |
| y_mant | input | 24 | Mantissa of y, hidden bit set |
| z_sign | input | 1 | Sign of z |
| z_exp | input | 10 | Signed exponent of z |
| z_mant | input | 24 | Mantissa of z, hidden bit set |
| z_zero | input | 1 | z is zero: pass the product through |
| neg_prod | input | 1 | Negate the product (z − x·y) |
| rmode | input | 2 | Rounding mode, used for the sign of an exact zero |
| out_valid | output | 1 | Result valid |
| out_sign | output | 1 | Result sign |
| out_exp | output | 10 | Result exponent, signed |
| out_mant | output | 27 | Result mantissa with guard, round and sticky |

## Verification
The assertions watch several properties on every cycle:
- the one-cycle valid timing and holding of results;
- the leading one at bit 26 of every non-zero mantissa;
- the sign and zero exponent of a cancelled result under each rounding mode;
- the product sign and non-zero mantissa whenever z is zero.

The exact mantissa and exponent values need the bench's directed operands with hand-derived results. These cover exponent renormalisation, sticky collection during alignment and final narrowing, carry on addition, deep cancellation and out-of-range exponents.

// File: rtl/fma_mant_pkg.sv
// Shared constants and types for the fused multiply-add mantissa datapath.
// Assumes single-precision operands that are already unpacked and normalised.
package fma_mant_pkg;
    localparam int MANT_W_D = 24;   // mantissa width including hidden bit
    localparam int EXP_W_D  = 10;   // signed exponent width
    localparam int WORD_W_D = 64;   // working word width
    localparam int OUT_W_D  = 27;   // output mantissa: 24 + guard, round, sticky

    // Rounding mode encoding seen at the rmode port
    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } rmode_e;
endpackage

// File: rtl/fma_sticky_shr.sv
// Right shift that ORs every bit shifted out into bit 0 of the result.
// Assumes AMT_W is wide enough to hold W-1; amounts of W-1 or more leave
// only the sticky bit.
module fma_sticky_shr #(
    parameter int W     = 64,
    parameter int AMT_W = 11
) (
    input  logic [W-1:0]     din,
    input  logic [AMT_W-1:0] amt,
    output logic [W-1:0]     dout
);
    logic [W-1:0] kept;
    logic         lost;

    // Shift, then fold the discarded bits into the lowest position
    always_comb begin
        kept = din >> amt;
        lost = |(din & ~({W{1'b1}} << amt));
        if (amt >= AMT_W'(W - 1)) begin
            dout = {{(W-1){1'b0}}, |din};
        end else begin
            dout = {kept[W-1:1], kept[0] | lost};
        end
    end
endmodule

// File: rtl/fma_prod_stage.sv
// Exact mantissa product placed in the working word with its leading one at
// bit WORD_W-2. Assumes both mantissas have the hidden bit set, so the raw
// product's leading one is in one of its top two bits.
module fma_prod_stage #(
    parameter int MANT_W = 24,
    parameter int EXP_W  = 10,
    parameter int WORD_W = 64
) (
    input  logic              x_sign,
    input  logic [EXP_W-1:0]  x_exp,
    input  logic [MANT_W-1:0] x_mant,
    input  logic              y_sign,
    input  logic [EXP_W-1:0]  y_exp,
    input  logic [MANT_W-1:0] y_mant,
    input  logic              neg_prod,
    output logic              p_sign,
    output logic [EXP_W-1:0]  p_exp,
    output logic [WORD_W-1:0] p_word
);
    localparam int PROD_W = 2 * MANT_W;
    localparam int PIN_SH = WORD_W - PROD_W;

    logic [PROD_W-1:0] prod;
    logic [WORD_W-1:0] raw;

    // Multiply, move to the top of the word and pin the leading one
    always_comb begin
        prod   = x_mant * y_mant;
        raw    = {prod, {PIN_SH{1'b0}}};
        p_word = raw[WORD_W-1] ? (raw >> 1) : raw;
        p_exp  = x_exp + y_exp + EXP_W'(raw[WORD_W-1]);
        p_sign = x_sign ^ y_sign ^ neg_prod;
    end
endmodule

// File: rtl/fma_align.sv
// Brings the product and z to a common exponent by sticky-shifting the one
// with the smaller exponent. Assumes z_mant has its hidden bit set.
module fma_align #(
    parameter int MANT_W = 24,
    parameter int EXP_W  = 10,
    parameter int WORD_W = 64
) (
    input  logic [EXP_W-1:0]  p_exp,
    input  logic [WORD_W-1:0] p_word,
    input  logic [EXP_W-1:0]  z_exp,
    input  logic [MANT_W-1:0] z_mant,
    output logic [WORD_W-1:0] a_p,
    output logic [WORD_W-1:0] a_z,
    output logic [EXP_W-1:0]  com_exp
);
    localparam int Z_SH  = WORD_W - 1 - MANT_W;
    localparam int AMT_W = EXP_W + 1;

    logic [AMT_W-1:0]  d;
    logic [AMT_W-1:0]  z_amt;
    logic [AMT_W-1:0]  p_amt;
    logic [WORD_W-1:0] z_word;

    // Exponent difference and per-operand shift amounts
    always_comb begin
        z_word  = {1'b0, z_mant, {Z_SH{1'b0}}};
        d       = {z_exp[EXP_W-1], z_exp} - {p_exp[EXP_W-1], p_exp};
        z_amt   = d[AMT_W-1] ? (~d + AMT_W'(1)) : '0;
        p_amt   = (!d[AMT_W-1] && (d != '0)) ? d : '0;
        com_exp = d[AMT_W-1] ? p_exp : z_exp;
    end

    fma_sticky_shr #(.W(WORD_W), .AMT_W(AMT_W)) u_shr_z (
        .din(z_word), .amt(z_amt), .dout(a_z)
    );

    fma_sticky_shr #(.W(WORD_W), .AMT_W(AMT_W)) u_shr_p (
        .din(p_word), .amt(p_amt), .dout(a_p)
    );
endmodule

// File: rtl/fma_sum_norm.sv
// Adds or subtracts the aligned words, renormalises to a leading one at
// bit WORD_W-2 and narrows to OUT_W bits with a sticky bit. Assumes both
// aligned words are below 2**(WORD_W-1).
module fma_sum_norm #(
    parameter int EXP_W  = 10,
    parameter int WORD_W = 64,
    parameter int OUT_W  = 27
) (
    input  logic              z_zero,
    input  logic              z_sign,
    input  logic              p_sign,
    input  logic [EXP_W-1:0]  p_exp,
    input  logic [WORD_W-2:0] p_word,
    input  logic [WORD_W-1:0] a_z,
    input  logic [WORD_W-1:0] a_p,
    input  logic [EXP_W-1:0]  com_exp,
    input  logic [1:0]        rmode,
    output logic              res_sign,
    output logic [EXP_W-1:0]  res_exp,
    output logic [OUT_W-1:0]  res_mant
);
    import fma_mant_pkg::*;

    localparam int LEAD   = WORD_W - 2;
    localparam int FIN_SH = LEAD - (OUT_W - 1);
    localparam int SH_W   = $clog2(WORD_W);

    logic [WORD_W-1:0] sum;
    logic [WORD_W-1:0] diff;
    logic [LEAD:0]     word;
    logic [SH_W-1:0]   lead_pos;
    logic [SH_W-1:0]   shamt;

    // Select the operation, then normalise the working word
    always_comb begin
        sum      = a_z + a_p;
        diff     = (a_z >= a_p) ? (a_z - a_p) : (a_p - a_z);
        lead_pos = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (diff[i]) lead_pos = SH_W'(i);
        end
        shamt    = SH_W'(LEAD) - lead_pos;
        word     = '0;
        res_exp  = com_exp;
        res_sign = z_sign;
        if (z_zero) begin
            word     = p_word;
            res_exp  = p_exp;
            res_sign = p_sign;
        end else if (z_sign == p_sign) begin
            if (sum[WORD_W-1]) begin
                word    = {sum[WORD_W-1:2], sum[1] | sum[0]};
                res_exp = com_exp + EXP_W'(1);
            end else begin
                word    = sum[LEAD:0];
            end
        end else if (diff == '0) begin
            res_sign = (rmode == RM_DOWN);
            res_exp  = '0;
        end else begin
            res_sign = (a_z >= a_p) ? z_sign : p_sign;
            word     = (LEAD+1)'(diff << shamt);
            res_exp  = com_exp - EXP_W'(shamt);
        end
    end

    // Narrow to the output width, keeping the dropped bits as sticky
    always_comb begin
        res_mant = {word[LEAD -: OUT_W-1], |word[FIN_SH:0]};
    end
endmodule

// File: rtl/fma_mant_core.sv
// Top of the fused multiply-add mantissa datapath: exact product, alignment,
// add/subtract and normalisation, with the result registered one cycle after
// an accepted operation. Assumes normalised operands; special values and
// rounding are handled by neighbouring stages.
module fma_mant_core #(
    parameter int MANT_W = fma_mant_pkg::MANT_W_D,
    parameter int EXP_W  = fma_mant_pkg::EXP_W_D,
    parameter int WORD_W = fma_mant_pkg::WORD_W_D,
    parameter int OUT_W  = fma_mant_pkg::OUT_W_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              x_sign,
    input  logic [EXP_W-1:0]  x_exp,
    input  logic [MANT_W-1:0] x_mant,
    input  logic              y_sign,
    input  logic [EXP_W-1:0]  y_exp,
    input  logic [MANT_W-1:0] y_mant,
    input  logic              z_sign,
    input  logic [EXP_W-1:0]  z_exp,
    input  logic [MANT_W-1:0] z_mant,
    input  logic              z_zero,
    input  logic              neg_prod,
    input  logic [1:0]        rmode,
    output logic              out_valid,
    output logic              out_sign,
    output logic [EXP_W-1:0]  out_exp,
    output logic [OUT_W-1:0]  out_mant
);
    localparam int LEAD = WORD_W - 2;

    logic              p_sign;
    logic [EXP_W-1:0]  p_exp;
    logic [WORD_W-1:0] p_word;
    logic [WORD_W-1:0] a_p;
    logic [WORD_W-1:0] a_z;
    logic [EXP_W-1:0]  com_exp;
    logic              res_sign;
    logic [EXP_W-1:0]  res_exp;
    logic [OUT_W-1:0]  res_mant;

    fma_prod_stage #(.MANT_W(MANT_W), .EXP_W(EXP_W), .WORD_W(WORD_W)) u_prod (
        .x_sign(x_sign), .x_exp(x_exp), .x_mant(x_mant),
        .y_sign(y_sign), .y_exp(y_exp), .y_mant(y_mant),
        .neg_prod(neg_prod),
        .p_sign(p_sign), .p_exp(p_exp), .p_word(p_word)
    );

    fma_align #(.MANT_W(MANT_W), .EXP_W(EXP_W), .WORD_W(WORD_W)) u_align (
        .p_exp(p_exp), .p_word(p_word), .z_exp(z_exp), .z_mant(z_mant),
        .a_p(a_p), .a_z(a_z), .com_exp(com_exp)
    );

    fma_sum_norm #(.EXP_W(EXP_W), .WORD_W(WORD_W), .OUT_W(OUT_W)) u_sum (
        .z_zero(z_zero), .z_sign(z_sign), .p_sign(p_sign), .p_exp(p_exp),
        .p_word(p_word[LEAD:0]), .a_z(a_z), .a_p(a_p), .com_exp(com_exp),
        .rmode(rmode),
        .res_sign(res_sign), .res_exp(res_exp), .res_mant(res_mant)
    );

    // Result register: capture on in_valid, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sign  <= 1'b0;
            out_exp   <= '0;
            out_mant  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sign <= res_sign;
                out_exp  <= res_exp;
                out_mant <= res_mant;
            end
        end
    end
endmodule

// File: rtl/fma_mant_core_checker.sv
// Cycle-by-cycle properties of the datapath's port behaviour; bound to the
// top module below.
module fma_mant_core_checker #(
    parameter int EXP_W = 10,
    parameter int OUT_W = 27
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             x_sign,
    input logic             y_sign,
    input logic             z_zero,
    input logic             neg_prod,
    input logic [1:0]       rmode,
    input logic             out_valid,
    input logic             out_sign,
    input logic [EXP_W-1:0] out_exp,
    input logic [OUT_W-1:0] out_mant
);
    // R1: a result follows every accepted operation one cycle later
    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1: with no operation the outputs hold and valid drops
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_mant) && $stable(out_exp) && $stable(out_sign)));

    // R3: product sign when z is zero
    p_prod_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && z_zero) |=> (out_sign == ($past(x_sign) ^ $past(y_sign) ^ $past(neg_prod))));

    // R4: a bare product is never zero
    p_prod_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && z_zero) |=> (out_mant != '0));

    // R8: exact cancellation gives zero exponent and mode-dependent sign
    p_zero_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mant == '0) |-> (out_exp == '0 && out_sign == ($past(rmode) == 2'b11)));

    // R9: a non-zero result is normalised to the top output bit
    p_lead_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mant != '0) |-> out_mant[OUT_W-1]);
endmodule

bind fma_mant_core fma_mant_core_checker #(.EXP_W(EXP_W), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .x_sign(x_sign), .y_sign(y_sign), .z_zero(z_zero), .neg_prod(neg_prod),
    .rmode(rmode), .out_valid(out_valid), .out_sign(out_sign),
    .out_exp(out_exp), .out_mant(out_mant)
);

// File: tb/fma_mant_core_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, expected values derived by hand.
module fma_mant_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        x_sign = 1'b0, y_sign = 1'b0, z_sign = 1'b0;
    logic [9:0]  x_exp = '0, y_exp = '0, z_exp = '0;
    logic [23:0] x_mant = 24'h800000, y_mant = 24'h800000, z_mant = 24'h800000;
    logic        z_zero = 1'b0, neg_prod = 1'b0;
    logic [1:0]  rmode = 2'b00;
    logic        out_valid, out_sign;
    logic [9:0]  out_exp;
    logic [26:0] out_mant;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [23:0] ONE  = 24'h800000;
    localparam logic [23:0] ONE5 = 24'hC00000;

    always #2 clk = ~clk;

    fma_mant_core u_fma_mant_core (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .x_sign(x_sign), .x_exp(x_exp), .x_mant(x_mant),
        .y_sign(y_sign), .y_exp(y_exp), .y_mant(y_mant),
        .z_sign(z_sign), .z_exp(z_exp), .z_mant(z_mant),
        .z_zero(z_zero), .neg_prod(neg_prod), .rmode(rmode),
        .out_valid(out_valid), .out_sign(out_sign),
        .out_exp(out_exp), .out_mant(out_mant)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d (0x%0h) expected %0d (0x%0h)", tag, got, got, exp, exp);
        end
    endtask

    // Drive one operation, then check the registered result and its hold
    task automatic run_op(input string tag,
                          input logic xs, input int xe, input logic [23:0] xm,
                          input logic ys, input int ye, input logic [23:0] ym,
                          input logic zs, input int ze, input logic [23:0] zm,
                          input logic zz, input logic ng, input logic [1:0] rm,
                          input logic es, input int ee, input int em);
        @(negedge clk);
        x_sign = xs; x_exp = 10'(xe); x_mant = xm;
        y_sign = ys; y_exp = 10'(ye); y_mant = ym;
        z_sign = zs; z_exp = 10'(ze); z_mant = zm;
        z_zero = zz; neg_prod = ng; rmode = rm; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        x_mant = 24'hFFFFFF; z_mant = 24'h812345; z_exp = 10'(7);
        check({tag, " valid (R1)"}, int'(out_valid), 1);
        check({tag, " sign"}, int'(out_sign), int'(es));
        check({tag, " exp"}, int'($signed(out_exp)), ee);
        check({tag, " mant"}, int'(out_mant), em);
        @(negedge clk);
        check({tag, " hold valid low (R1)"}, int'(out_valid), 0);
        check({tag, " hold mant (R1)"}, int'(out_mant), em);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset mant", int'(out_mant), 0);
        check("R1 reset exp", int'(out_exp), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_product;
        run_op("R2 1x1", 0,0,ONE, 0,0,ONE, 0,0,ONE, 1,0,2'b00, 0,0,'h4000000);
        run_op("R2 1.5x1.5 renorm", 0,0,ONE5, 0,0,ONE5, 0,0,ONE, 1,0,2'b00, 0,1,'h4800000);
        run_op("R2 exp sum", 0,5,ONE, 0,-3,ONE, 0,0,ONE, 1,0,2'b00, 0,2,'h4000000);
        run_op("R3 neg x", 1,0,ONE, 0,0,ONE, 0,0,ONE, 1,0,2'b00, 1,0,'h4000000);
        run_op("R3 neg_prod", 0,0,ONE, 0,0,ONE, 0,0,ONE, 1,1,2'b00, 1,0,'h4000000);
        run_op("R3 neg_prod neg x", 1,0,ONE, 0,0,ONE, 0,0,ONE, 1,1,2'b00, 0,0,'h4000000);
    endtask

    task automatic t_zzero_ignores_z;
        run_op("R4 z fields ignored", 0,0,ONE5, 0,0,ONE5, 1,50,24'hFFFFFF, 1,0,2'b11, 0,1,'h4800000);
    endtask

    task automatic t_addition;
        run_op("R6 1+1 carry", 0,0,ONE, 0,0,ONE, 0,0,ONE, 0,0,2'b00, 0,1,'h4000000);
        run_op("R6 negative add", 1,0,ONE, 0,0,ONE, 1,0,ONE, 0,0,2'b00, 1,1,'h4000000);
        run_op("R6 carry low bits", 0,0,24'h800001, 0,0,ONE, 0,0,ONE, 0,0,2'b00, 0,1,'h4000004);
    endtask

    task automatic t_align;
        run_op("R5 product sticky", 0,-40,ONE, 0,0,ONE, 0,0,ONE, 0,0,2'b00, 0,0,'h4000001);
        run_op("R5 z shifted past word", 0,0,ONE, 0,0,ONE, 0,-100,ONE, 0,0,2'b00, 0,0,'h4000001);
        run_op("R5 product shifted past word", 0,0,ONE, 0,0,ONE, 0,100,ONE, 0,0,2'b00, 0,100,'h4000001);
    endtask

    task automatic t_subtract;
        run_op("R7 z larger", 0,0,ONE, 0,0,ONE, 0,0,ONE5, 0,1,2'b00, 0,-1,'h4000000);
        run_op("R7 product larger", 0,0,ONE5, 0,0,ONE, 0,0,ONE, 0,1,2'b00, 1,-1,'h4000000);
        run_op("R7 negative z", 0,0,ONE5, 0,0,ONE, 1,0,ONE, 0,0,2'b00, 0,-1,'h4000000);
        run_op("R9 deep cancel", 0,0,ONE, 0,0,ONE, 0,0,24'h800001, 0,1,2'b00, 0,-23,'h4000000);
    endtask

    task automatic t_exact_zero;
        run_op("R8 zero mode down", 0,0,ONE, 0,0,ONE, 0,0,ONE, 0,1,2'b11, 1,0,0);
        run_op("R8 zero mode nearest", 0,0,ONE, 0,0,ONE, 0,0,ONE, 0,1,2'b00, 0,0,0);
        run_op("R8 zero mode up", 1,3,ONE, 0,4,ONE, 1,7,ONE, 0,1,2'b10, 0,0,0);
    endtask

    task automatic t_narrow_and_range;
        run_op("R10 sticky narrowing", 0,0,24'h800001, 0,0,24'h800001, 0,0,ONE, 1,0,2'b00, 0,0,'h4000011);
        run_op("R11 high exp", 0,127,ONE5, 0,127,ONE5, 0,0,ONE, 1,0,2'b00, 0,255,'h4800000);
        run_op("R11 low exp", 0,-149,ONE, 0,-149,ONE, 0,0,ONE, 1,0,2'b00, 0,-298,'h4000000);
    endtask

    initial begin
        t_reset();
        t_product();
        t_zzero_ignores_z();
        t_addition();
        t_align();
        t_subtract();
        t_exact_zero();
        t_narrow_and_range();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule